// File: doc/BRIEF.md
# Down-Counting Interval Timer with APB Register Access

This block is one 32-bit timer channel behind an APB slave port. When software enables it, the counter starts from a programmed start value. It then steps down by one on every clock. On each expiry it sets a sticky interrupt flag. Whether that flag drives the interrupt line is decided by a mask bit whose set state blocks the line.

On expiry the counter does one of two things:
- In free-running mode it wraps to all ones, so software can read the inverted count as a rising timebase.
- In periodic mode it restarts from the stored start value, which gives a steady tick.

The flag is acknowledged by reading an end-of-interrupt location. Writing to it does nothing. A per-channel set of locations and a global mirror set both expose the flag, and the global set also holds a fixed version word. Transfers always complete in one access phase.

Top module: `apb_down_timer`

## Requirements
- R1: After reset the start-value register, count, control bits and interrupt flag are all zero and `irq_o` is low.
- R2: Writing the control word at offset 0x08 with bit 0 (enable) set while enable was clear loads the count from the start-value register at offset 0x00. After that, each clock lowers the count by one. The count is read at offset 0x04.
- R3: While enable is clear the count holds its value.
- R4: With control bit 1 clear (free-running), an enabled count of zero becomes 0xFFFFFFFF on the next clock.
- R5: With control bit 1 set (periodic), an enabled count of zero reloads the start value on the next clock.
- R6: The raw interrupt flag is set on the clock where an enabled count leaves zero, whatever the mask. It reads as bit 0 of offset 0xA8.
- R7: Control bit 2 is the mask, and 1 blocks the interrupt. `irq_o` and bit 0 of offsets 0x10 and 0xA0 equal raw AND NOT mask.
- R8: A read at offset 0x0C or 0xA4 returns zero and clears the raw flag, unless a new expiry happens in that same clock.
- R9: A read at offset 0xAC returns the VERSION parameter.
- R10: Writes to read-only offsets (0x04, 0xAC) and to undefined offsets change nothing. Reads from undefined offsets return zero. `pready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | CNT_W | Write data |
| prdata | output | CNT_W | Read data |
| pready | output | 1 | Transfer done, tied high |
| irq_o | output | 1 | Level interrupt, masked flag |

## Verification
The main function is driven from a table of start values and modes, with a different wait before the count is read for each entry.
- Short waits check the plain decrement.
- Waits longer than the start value separate a wrap to all ones from a reload.
- A start value of zero separates an immediate wrap from a reload that sticks at zero.
- A wait of two full periods confirms that periodic reload repeats.

Directed runs then time the interrupt edge to the exact clock and set the mask against a pending flag. They also acknowledge through each end-of-interrupt location and attempt writes to read-only locations.

// File: rtl/apb_down_timer.sv
module apb_down_timer #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [CNT_W-1:0] VERSION = 32'h3230_312A
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic              pready,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] A_GACK  = ADDR_W'('hA4);
  localparam logic [ADDR_W-1:0] A_GRAW  = ADDR_W'('hA8);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'('hAC);

  logic [CNT_W-1:0] start_q, count_q;
  logic [2:0]       ctrl_q;
  logic             raw_q;

  wire wr_acc   = psel & penable & pwrite;
  wire rd_acc   = psel & penable & ~pwrite;
  wire ctrl_wr  = wr_acc && (paddr == A_CTRL);
  wire run      = ctrl_q[0];
  wire periodic = ctrl_q[1];
  wire mask     = ctrl_q[2];
  wire kick     = ctrl_wr && pwdata[0] && !run;
  wire expire   = run && !kick && (count_q == '0);
  wire ack_rd   = rd_acc && ((paddr == A_ACK) || (paddr == A_GACK));
  wire pend     = raw_q & ~mask;

  assign pready = 1'b1;
  assign irq_o  = pend;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      start_q <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_acc && (paddr == A_START)) start_q <= pwdata;
      if (ctrl_wr) ctrl_q <= pwdata[2:0];

      if (kick) count_q <= start_q;
      else if (run) begin
        if (count_q == '0) count_q <= periodic ? start_q : '1;
        else count_q <= count_q - 1'b1;
      end

      if (expire) raw_q <= 1'b1;
      else if (ack_rd) raw_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_START: prdata = start_q;
      A_COUNT: prdata = count_q;
      A_CTRL:  prdata = CNT_W'(ctrl_q);
      A_STAT,
      A_GSTAT: prdata = CNT_W'(pend);
      A_GRAW:  prdata = CNT_W'(raw_q);
      A_VER:   prdata = VERSION;
      default: prdata = '0;
    endcase
  end
endmodule

module apb_down_timer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              irq,
  input logic [2:0]        ctrl,
  input logic [CNT_W-1:0]  start,
  input logic [CNT_W-1:0]  count,
  input logic              raw
);
  wire ctrl_wr = psel && penable && pwrite && (paddr == ADDR_W'('h08));
  wire ack = psel && penable && !pwrite &&
             ((paddr == ADDR_W'('h0C)) || (paddr == ADDR_W'('hA4)));

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && count != '0 && !ctrl_wr) |=> count == $past(count) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl_wr) |=> $stable(count));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && count == '0 && !ctrl_wr) |=> (count == '1 && raw));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[1] && count == '0 && !ctrl_wr) |=> (count == $past(start) && raw));
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[2] |-> !irq);
  a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(ctrl[0] && count == '0)) |=> !raw);
endmodule

bind apb_down_timer apb_down_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .irq(irq_o), .ctrl(ctrl_q), .start(start_q), .count(count_q),
  .raw(raw_q));

// File: tb/apb_down_timer_tb.sv
module apb_down_timer_tb;
  localparam logic [31:0] VER = 32'h3230_312A;

  logic clk = 1'b0, presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  apb_down_timer u_dut (.pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq_o(irq_o));

  // start value, periodic, extra wait, expected count
  localparam logic [31:0] VEC [7][4] = '{
    '{32'd10, 32'd0, 32'd0, 32'd9},
    '{32'd10, 32'd0, 32'd5, 32'd4},
    '{32'd2,  32'd0, 32'd3, 32'hFFFF_FFFE},
    '{32'd2,  32'd1, 32'd3, 32'd1},
    '{32'd0,  32'd1, 32'd2, 32'd0},
    '{32'd0,  32'd0, 32'd0, 32'hFFFF_FFFF},
    '{32'd3,  32'd1, 32'd7, 32'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v1;
    repeat (3) @(negedge clk);
    presetn = 1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h00, d); chk("R1 start", d, 0);
    rd(8'h04, d); chk("R1 count", d, 0);
    rd(8'hA8, d); chk("R1 raw", d, 0);
    rd(8'hAC, d); chk("R9 version", d, VER);
    chk("R10 pready", {31'b0, pready}, 1);

    for (int i = 0; i < 7; i++) begin
      wr(8'h08, 0);
      rd(8'h0C, d);
      wr(8'h00, VEC[i][0]);
      wr(8'h08, {30'b0, VEC[i][1][0], 1'b1});
      repeat (VEC[i][2]) @(negedge clk);
      rd(8'h04, d);
      chk($sformatf("R2/R4/R5 vector %0d", i), d, VEC[i][3]);
    end

    wr(8'h08, 0);
    rd(8'h04, v1);
    repeat (5) @(negedge clk);
    rd(8'h04, d); chk("R3 hold", d, v1);

    rd(8'h0C, d);
    wr(8'h00, 3);
    wr(8'h08, 1);
    repeat (3) @(negedge clk);
    chk("R6 no irq at zero", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R6 irq after zero", {31'b0, irq_o}, 1);
    rd(8'hA8, d); chk("R6 raw", d, 1);
    rd(8'h10, d); chk("R7 status", d, 1);
    rd(8'hA0, d); chk("R7 global status", d, 1);
    wr(8'h08, 5);
    chk("R7 masked irq", {31'b0, irq_o}, 0);
    rd(8'hA8, d); chk("R6 raw under mask", d, 1);
    rd(8'h10, d); chk("R7 masked status", d, 0);
    rd(8'hA0, d); chk("R7 masked global", d, 0);
    rd(8'h0C, d); chk("R8 ack data", d, 0);
    rd(8'hA8, d); chk("R8 raw cleared", d, 0);
    wr(8'h08, 1);
    chk("R8 irq after unmask", {31'b0, irq_o}, 0);

    wr(8'h08, 0);
    wr(8'h00, 1);
    wr(8'h08, 1);
    repeat (2) @(negedge clk);
    chk("R8 irq before global ack", {31'b0, irq_o}, 1);
    rd(8'hA4, d); chk("R8 global ack data", d, 0);
    rd(8'hA8, d); chk("R8 global ack clears", d, 0);
    chk("R8 irq low", {31'b0, irq_o}, 0);

    wr(8'h08, 0);
    rd(8'h04, v1);
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, d); chk("R10 count write ignored", d, v1);
    wr(8'hAC, 32'h0);
    rd(8'hAC, d); chk("R10 version write ignored", d, VER);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R10 undefined read", d, 0);
    rd(8'h00, d); chk("R10 start untouched", d, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule